// File: doc/BRIEF.md
# Ring-Prescaled Wide Binary Counter

This block is a free-running, fully synchronous binary up-counter meant for clock rates where a full-width carry chain cannot close timing in one cycle. The low-order bits are not computed by an adder. Each one is the output tap of its own rotating shift register. Bit k uses a register of 2^(k+1) stages, with half of the stages set to one and half set to zero. Only flop-to-flop wiring sits between stages, so the single-cycle timing path is one flop output driving the next flop input.

A separate rotating register holds a single one. Its tap pulses high for one cycle in every prescaler period. That pulse is the only thing that advances an ordinary binary counter holding the upper bits. The upper counter moves once every 2^PRE_BITS cycles, so its carry logic can be constrained as a multicycle path. The pulse ring is built in several identical copies, and each copy enables one slice of the upper register, which keeps the fanout of each copy low.

The block has one asynchronous clear and no load, preset or count direction. PRE_BITS chooses a 4-bit prescaler (upper counter of WIDTH-4 bits, stepping every 16 clocks) or a 3-bit prescaler (WIDTH-3 bits, stepping every 8 clocks). The block has no streaming data, so its pins are plain control and status signals with no valid/ready handshake and no back-pressure.

Top module: `prc_counter`

## Requirements
- R1: While `clear` is high, `count` reads zero. Clearing takes effect at once and does not wait for a clock edge.
- R2: After `clear` is released, `count` reads 0, 1, 2, ... and rises by exactly one on every rising clock edge.
- R3: Bit k of `count`, for k below PRE_BITS, has a period of 2^(k+1) clocks. It is low for the first half of each period and high for the second half, and it starts low after clear.
- R4: The upper field `count[WIDTH-1:PRE_BITS]` changes only at the edge where the low PRE_BITS bits go from all ones to zero. The internal enable pulse is high on exactly those cycles.
- R5: All enable copies agree on every cycle, and the upper field stays unchanged on every cycle where the enable is low.
- R6: When the count reaches all ones it wraps to zero on the next edge and then keeps counting.
- R7: With PRE_BITS = 3 the output follows the same sequence as in R2, and the upper field steps once every 8 clocks.
- R8: If `clear` is raised in the middle of a count, the count restarts from 0 once `clear` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| clear | input | 1 | Asynchronous clear, active high |
| count | output | WIDTH | Current count value |

## Verification
The hardest case to reach is the wrap of the upper counter. With WIDTH = 32 it needs 2^32 clocks, and the block has no load input that could jump close to the end. The bench therefore runs narrow 8-bit instances next to the full-width ones, with both prescaler sizes. In those instances the upper field overflows after 256 clocks, which is well within a short run. All instances are compared against a single reference count on every cycle, and a clear is applied in the middle of a count.

// File: rtl/prc_pkg.sv
package prc_pkg;
  // number of stages of the rotating register that makes prescaler bit k
  function automatic int ring_len(input int k);
    return 2 ** (k + 1);
  endfunction

  // clocks per prescaler period
  function automatic int pre_period(input int pre_bits);
    return 2 ** pre_bits;
  endfunction

  // width of one slice of the upper counter, given the number of enable copies
  function automatic int slice_width(input int up_w, input int copies);
    return (up_w + copies - 1) / copies;
  endfunction
endpackage

// File: rtl/prc_bit_ring.sv
module prc_bit_ring #(
  parameter int K = 0
) (
  input  logic clk,
  input  logic clear,
  output logic tap
);
  localparam int LEN  = prc_pkg::ring_len(K);
  localparam int HALF = LEN / 2;
  localparam logic [LEN-1:0] SEED = {{HALF{1'b1}}, {HALF{1'b0}}};

  logic [LEN-1:0] stg;

  // shift toward stage 0; stage 0 is the output tap
  always_ff @(posedge clk or posedge clear) begin
    if (clear) stg <= SEED;
    else       stg <= {stg[0], stg[LEN-1:1]};
  end

  assign tap = stg[0];
endmodule

// File: rtl/prc_enable_ring.sv
module prc_enable_ring #(
  parameter int LEN    = 16,
  parameter int COPIES = 4
) (
  input  logic              clk,
  input  logic              clear,
  output logic [COPIES-1:0] en
);
  localparam logic [LEN-1:0] SEED = {1'b1, {(LEN-1){1'b0}}};

  // identical one-hot rings, each one driving a single slice of the upper counter
  for (genvar c = 0; c < COPIES; c++) begin : g_copy
    logic [LEN-1:0] stg;
    always_ff @(posedge clk or posedge clear) begin
      if (clear) stg <= SEED;
      else       stg <= {stg[0], stg[LEN-1:1]};
    end
    assign en[c] = stg[0];
  end
endmodule

// File: rtl/prc_upper_cnt.sv
module prc_upper_cnt #(
  parameter int UP_W   = 28,
  parameter int COPIES = 4
) (
  input  logic              clk,
  input  logic              clear,
  input  logic [COPIES-1:0] en,
  output logic [UP_W-1:0]   value
);
  localparam int SL = prc_pkg::slice_width(UP_W, COPIES);

  logic [UP_W-1:0] nxt;

  // multicycle path: the result is used only once per prescaler period
  assign nxt = value + UP_W'(1);

  for (genvar s = 0; s < COPIES; s++) begin : g_slice
    localparam int LO = s * SL;
    localparam int HI = (LO + SL > UP_W) ? UP_W - 1 : LO + SL - 1;
    if (LO < UP_W) begin : g_used
      always_ff @(posedge clk or posedge clear) begin
        if (clear)      value[HI:LO] <= '0;
        else if (en[s]) value[HI:LO] <= nxt[HI:LO];
      end
    end
  end
endmodule

// File: rtl/prc_counter.sv
module prc_counter #(
  parameter int WIDTH     = 32,
  parameter int PRE_BITS  = 4,
  parameter int EN_COPIES = 4
) (
  input  logic             clk,
  input  logic             clear,
  output logic [WIDTH-1:0] count
);
  localparam int UP_W   = WIDTH - PRE_BITS;
  localparam int PERIOD = prc_pkg::pre_period(PRE_BITS);

  logic [PRE_BITS-1:0]  low;
  logic [EN_COPIES-1:0] en_vec;
  logic [UP_W-1:0]      upper;

  for (genvar k = 0; k < PRE_BITS; k++) begin : g_low
    prc_bit_ring #(.K(k)) u_ring (
      .clk   (clk),
      .clear (clear),
      .tap   (low[k])
    );
  end

  prc_enable_ring #(.LEN(PERIOD), .COPIES(EN_COPIES)) u_en (
    .clk   (clk),
    .clear (clear),
    .en    (en_vec)
  );

  prc_upper_cnt #(.UP_W(UP_W), .COPIES(EN_COPIES)) u_up (
    .clk   (clk),
    .clear (clear),
    .en    (en_vec),
    .value (upper)
  );

  assign count = {upper, low};
endmodule

// File: rtl/prc_counter_chk.sv
module prc_counter_chk #(
  parameter int WIDTH     = 32,
  parameter int PRE_BITS  = 4,
  parameter int EN_COPIES = 4
) (
  input logic                 clk,
  input logic                 clear,
  input logic [WIDTH-1:0]     count,
  input logic [EN_COPIES-1:0] en_vec
);
  logic armed;

  always_ff @(posedge clk or posedge clear) begin
    if (clear) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) clear |-> count == '0); // R1
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (clear)
    armed |-> count == WIDTH'($past(count) + 1'b1)); // R2
  AST_BIT0_TOGGLE: assert property (@(posedge clk) disable iff (clear)
    armed |-> count[0] != $past(count[0])); // R3
  AST_EN_AT_ALL_ONES: assert property (@(posedge clk) disable iff (clear)
    en_vec[0] == (&count[PRE_BITS-1:0])); // R4
  AST_EN_COPIES_AGREE: assert property (@(posedge clk) disable iff (clear)
    en_vec == {EN_COPIES{en_vec[0]}}); // R5
  AST_UPPER_HOLD: assert property (@(posedge clk) disable iff (clear)
    !en_vec[0] |=> $stable(count[WIDTH-1:PRE_BITS])); // R5
endmodule

bind prc_counter prc_counter_chk #(
  .WIDTH(WIDTH), .PRE_BITS(PRE_BITS), .EN_COPIES(EN_COPIES)
) u_chk (
  .clk(clk), .clear(clear), .count(count), .en_vec(en_vec)
);

// File: tb/prc_counter_test.sv
module prc_counter_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 9;
  localparam int unsigned VEC_CYC [NV] = '{0, 1, 7, 8, 15, 16, 17, 33, 300};
  localparam int unsigned VEC_EXP [NV] = '{0, 1, 7, 8, 15, 16, 17, 33, 300};

  logic clk = 1'b0;
  logic clear = 1'b1;
  logic [31:0] cnt4, cnt3;
  logic [7:0]  nar4, nar3;
  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prc_counter #(.WIDTH(32), .PRE_BITS(4)) uut    (.clk(clk), .clear(clear), .count(cnt4));
  prc_counter #(.WIDTH(32), .PRE_BITS(3)) uut_p3 (.clk(clk), .clear(clear), .count(cnt3));
  prc_counter #(.WIDTH(8),  .PRE_BITS(4)) uut_w4 (.clk(clk), .clear(clear), .count(nar4));
  prc_counter #(.WIDTH(8),  .PRE_BITS(3)) uut_w3 (.clk(clk), .clear(clear), .count(nar3));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic restart();
    @(negedge clk) clear = 1'b1;
    @(negedge clk) clear = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] ref_cnt;
    logic [31:0] prev4, prev3;
    repeat (3) @(negedge clk);
    chk("R1 reset 4-bit", cnt4, 32'd0);
    chk("R1 reset 3-bit", cnt3, 32'd0);
    chk("R1 reset narrow", {16'd0, nar4, nar3}, 32'd0);

    // table walk: clocks since clear -> expected count
    for (int v = 0; v < NV; v++) begin
      restart();
      repeat (VEC_CYC[v]) @(negedge clk);
      chk("R2 table 4-bit", cnt4, VEC_EXP[v]);
      chk("R7 table 3-bit", cnt3, VEC_EXP[v]);
      chk("R3 table low bits", {28'd0, cnt4[3:0]}, VEC_EXP[v] & 32'hf);
      chk("R6 table narrow 4-bit", {24'd0, nar4}, VEC_EXP[v] & 32'hff);
      chk("R6 table narrow 3-bit", {24'd0, nar3}, VEC_EXP[v] & 32'hff);
    end

    // cycle-by-cycle comparison against a reference count
    restart();
    ref_cnt = 32'd0;
    for (int i = 0; i < 600; i++) begin
      prev4 = cnt4;
      prev3 = cnt3;
      @(negedge clk);
      ref_cnt = ref_cnt + 32'd1;
      chk("R2 stream 4-bit", cnt4, ref_cnt);
      chk("R7 stream 3-bit", cnt3, ref_cnt);
      chk("R4 upper steps at low wrap only",
          {31'd0, (cnt4[31:4] != prev4[31:4])}, {31'd0, (prev4[3:0] == 4'hf)});
      chk("R7 upper steps every 8",
          {31'd0, (cnt3[31:3] != prev3[31:3])}, {31'd0, (prev3[2:0] == 3'h7)});
      chk("R5 upper field", {4'd0, cnt4[31:4]}, ref_cnt >> 4);
      chk("R6 narrow 4-bit", {24'd0, nar4}, ref_cnt & 32'hff);
      chk("R6 narrow 3-bit", {24'd0, nar3}, ref_cnt & 32'hff);
      if (ref_cnt == 32'd256 || ref_cnt == 32'd512)
        chk("R6 wrap to zero", {24'd0, nar4}, 32'd0);
    end

    // clear in the middle of a count, away from any clock edge
    #2 clear = 1'b1;
    #1;
    chk("R1 async clear 4-bit", cnt4, 32'd0);
    chk("R8 mid-count clear 3-bit", cnt3, 32'd0);
    @(negedge clk) clear = 1'b0;
    repeat (5) @(negedge clk);
    chk("R8 restart 4-bit", cnt4, 32'd5);
    chk("R8 restart 3-bit", cnt3, 32'd5);
    chk("R8 restart narrow", {24'd0, nar4}, 32'd5);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule